// File: doc/BRIEF.md
# Hard-Decision Register-Exchange Viterbi Decoder

This block decodes a rate-1/2 convolutional code with constraint length 4, whose generators are 1+D+D^2+D^3 (first output) and 1+D^2+D^3 (second output). It works on hard decisions: each received symbol is two bits. Eight identical state elements run in parallel, one for each of the eight 3-bit encoder states. Each element holds an accumulated Hamming weight and a survivor bit string of length `TB_LEN`. On every step, all elements see the same received symbol. Each element compares its two incoming candidates, keeps the better one, adds that candidate's branch weight once, and shifts the hypothesised input bit into the chosen survivor.

A block starts with a one-cycle `start_i` pulse. The block then takes `TB_LEN` symbols, one per cycle. After the last symbol, a comparator picks the survivor of the state with the smallest accumulated weight. That survivor leaves the block as the decoded word, together with a one-cycle `done_o` strobe. No trace-back memory exists: the survivors themselves are the decoded bits.

Top module: `rex_viterbi`

## Requirements
- R1: For state P (3 bits) and hypothesised input bit i, the next state is {i, P[2:1]}. The expected symbol is {i^P[2]^P[1]^P[0], i^P[1]^P[0]}, with the first generator's output in bit 1. For example, state 0 with input 1 goes to state 4 and expects symbol 11.
- R2: The branch weight is the number of ones in (expected symbol XOR received symbol), a value from 0 to 2. A state's weight is the sum of the branch weights along its survivor path.
- R3: Each state Q keeps the lower-weight candidate from its predecessors {Q[1:0],0} and {Q[1:0],1}. On equal candidate weights it keeps {Q[1:0],0}.
- R4: The new survivor of state Q is the chosen predecessor's survivor shifted left by one, with Q[2] placed at the LSB. The decision for the first symbol of a block therefore ends up at bit TB_LEN-1 of `bits_o`.
- R5: When a block is accepted, state 0 starts with weight 0 and every other state starts at 2^MW-1, where MW = clog2(2*TB_LEN+1). Accumulated weights saturate at 2^MW-1.
- R6: The decoded word is the survivor of the state with the smallest final weight. On a tie, the lowest-numbered state wins.
- R7: If `start_i` is high in a cycle while the block is idle, `sym_i` is taken during each of the next TB_LEN cycles. `done_o` is then high for exactly one cycle, TB_LEN+2 cycles after the start cycle. `bits_o` changes only at that strobe and holds its value until the next strobe.
- R8: `start_i` is ignored from the cycle after an accepted start until the done cycle. A new block may start in the done cycle itself.
- R9: A block of error-free symbols, encoded starting from state 0, decodes to exactly the encoder's input bits.
- R10: During and right after reset, `done_o` is 0 and `bits_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a block (accepted only while idle) |
| sym_i | input | 2 | Received hard-decision symbol, first generator in bit 1 |
| done_o | output | 1 | One-cycle strobe: decoded word valid |
| bits_o | output | TB_LEN | Decoded word, first symbol's bit at the MSB |

## Verification
The bench builds the decoder with TB_LEN = 8. This gives a 5-bit weight with a saturation ceiling of 31. The states other than state 0 start at the ceiling, and during the first three steps they add branch weights on top of it, so the saturating path is exercised in every block. A block of eight symbols is long enough for a single channel error to be corrected fully inside the block. It is also short enough that an error in the final symbol produces an exact tie between two end states, which exercises the lowest-index rule. Blocks run back to back, with starts injected mid-block, and are compared every cycle against a behavioural model.

// File: rtl/rex_pkg.sv
package rex_pkg;

  localparam int unsigned NST = 8;   // encoder states (constraint length 4)
  localparam int unsigned SW  = 3;   // state index width

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_e;

  // R1: code symbol emitted when input i leaves state p (bit 1 = first generator)
  function automatic logic [1:0] exp_sym(input logic [SW-1:0] p, input logic i);
    exp_sym = {i ^ p[2] ^ p[1] ^ p[0], i ^ p[1] ^ p[0]};
  endfunction

endpackage

// File: rtl/rex_ctrl.sv
module rex_ctrl
  import rex_pkg::*;
#(
  parameter int unsigned TB_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic init_o,
  output logic step_o,
  output logic fin_o
);

  localparam int unsigned CW = (TB_LEN > 1) ? $clog2(TB_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(TB_LEN - 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    init_o  = 1'b0;
    step_o  = 1'b0;
    fin_o   = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin           // R8: start only honoured here
          init_o  = 1'b1;
          phase_d = PH_RUN;
          cnt_d   = '0;
        end
      end
      PH_RUN: begin
        step_o = 1'b1;
        if (cnt_q == LAST) phase_d = PH_FIN;
        else               cnt_d   = cnt_q + 1'b1;
      end
      PH_FIN: begin
        fin_o   = 1'b1;
        phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  // R7: the final phase follows a symbol step; an accepted start is followed by a step
  p_fin_after_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> $past(step_o));
  p_init_then_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |=> step_o);
  // R8: a start during a block never re-initialises
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && start_i) |=> !init_o);

endmodule

// File: rtl/rex_pe.sv
module rex_pe
  import rex_pkg::*;
#(
  parameter int unsigned    TB_LEN = 8,
  parameter int unsigned    MW     = 5,
  parameter logic [SW-1:0]  ST     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              step_i,
  input  logic [1:0]        sym_i,
  input  logic [MW-1:0]     m_lo_i,
  input  logic [MW-1:0]     m_hi_i,
  input  logic [TB_LEN-1:0] s_lo_i,
  input  logic [TB_LEN-1:0] s_hi_i,
  output logic [MW-1:0]     metric_o,
  output logic [TB_LEN-1:0] surv_o
);

  localparam logic [SW-1:0] P_LO = {ST[1:0], 1'b0};
  localparam logic          HYP  = ST[2];
  localparam logic [MW-1:0] MAXW = '1;
  localparam logic [MW-1:0] INIT = (ST == '0) ? '0 : MAXW;

  logic [1:0]        dif_lo, w_lo, w_hi, w_sel;
  logic [MW+1:0]     lhs, rhs;
  logic              take_hi;
  logic [MW-1:0]     m_sel, metric_q, metric_d, metric_nx;
  logic [MW:0]       sum;
  logic [TB_LEN-1:0] s_sel, surv_q, surv_d, surv_nx;

  // R2: weight towards the lower predecessor; the upper one expects the complement
  always_comb begin
    dif_lo = exp_sym(P_LO, HYP) ^ sym_i;
    w_lo   = {1'b0, dif_lo[1]} + {1'b0, dif_lo[0]};
    w_hi   = 2'd2 - w_lo;
  end

  // R3: compare first (m_hi + 2 - w_lo < m_lo + w_lo), then one add on the winner
  always_comb begin
    lhs     = (MW+2)'(m_hi_i) + (MW+2)'(2);
    rhs     = (MW+2)'(m_lo_i) + (MW+2)'({w_lo, 1'b0});
    take_hi = lhs < rhs;
    m_sel   = take_hi ? m_hi_i : m_lo_i;
    w_sel   = take_hi ? w_hi   : w_lo;
    s_sel   = take_hi ? s_hi_i : s_lo_i;
    sum     = (MW+1)'(m_sel) + (MW+1)'(w_sel);
    metric_nx = sum[MW] ? MAXW : sum[MW-1:0];          // R5 saturation
    surv_nx   = {s_sel[TB_LEN-2:0], HYP};              // R4
  end

  always_comb begin
    metric_d = metric_q;
    surv_d   = surv_q;
    if (init_i) begin
      metric_d = INIT;
      surv_d   = '0;
    end else if (step_i) begin
      metric_d = metric_nx;
      surv_d   = surv_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metric_q <= '0;
      surv_q   <= '0;
    end else begin
      metric_q <= metric_d;
      surv_q   <= surv_d;
    end
  end

  assign metric_o = metric_q;
  assign surv_o   = surv_q;

  p_block_init_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (metric_q == INIT && surv_q == '0));
  p_lsb_is_hyp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |=> surv_q[0] == HYP);
  p_not_above_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |=> ((MW+2)'(metric_q) <= $past((MW+2)'(m_lo_i)) + (MW+2)'(2)));
  p_not_below_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !init_i) |=> (metric_q >= $past(m_lo_i) || metric_q >= $past(m_hi_i)));

endmodule

// File: rtl/rex_minsel.sv
module rex_minsel
  import rex_pkg::*;
#(
  parameter int unsigned TB_LEN = 8,
  parameter int unsigned MW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MW-1:0]     met_i  [NST],
  input  logic [TB_LEN-1:0] surv_i [NST],
  output logic [TB_LEN-1:0] best_o
);

  logic [SW-1:0] idx;
  logic [MW-1:0] best_m;

  // R6: strict less-than scan keeps the lowest index on ties
  always_comb begin
    idx    = '0;
    best_m = met_i[0];
    for (int j = 1; j < NST; j++) begin
      if (met_i[j] < best_m) begin
        best_m = met_i[j];
        idx    = SW'(j);
      end
    end
    best_o = surv_i[idx];
  end

  for (genvar g = 0; g < NST; g++) begin : g_chk
    p_is_minimum_r6: assert property (@(posedge clk) disable iff (!rst_n)
      met_i[g] >= met_i[idx]);
    p_tie_lowest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (met_i[g] == met_i[idx]) |-> (idx <= SW'(g)));
  end

endmodule

// File: rtl/rex_viterbi.sv
module rex_viterbi
  import rex_pkg::*;
#(
  parameter int unsigned TB_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        sym_i,
  output logic              done_o,
  output logic [TB_LEN-1:0] bits_o
);

  localparam int unsigned MW = $clog2(2 * TB_LEN + 1);

  logic              init, step, fin;
  logic [MW-1:0]     metric [NST];
  logic [TB_LEN-1:0] surv   [NST];
  logic [TB_LEN-1:0] best;
  logic              done_q, done_d;
  logic [TB_LEN-1:0] bits_q, bits_d;

  rex_ctrl #(.TB_LEN(TB_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .init_o(init), .step_o(step), .fin_o(fin)
  );

  for (genvar s = 0; s < NST; s++) begin : g_pe
    localparam int unsigned LO = (2 * s) % NST;
    rex_pe #(.TB_LEN(TB_LEN), .MW(MW), .ST(SW'(s))) u_pe (
      .clk(clk), .rst_n(rst_n), .init_i(init), .step_i(step), .sym_i(sym_i),
      .m_lo_i(metric[LO]), .m_hi_i(metric[LO + 1]),
      .s_lo_i(surv[LO]),   .s_hi_i(surv[LO + 1]),
      .metric_o(metric[s]), .surv_o(surv[s])
    );
  end

  rex_minsel #(.TB_LEN(TB_LEN), .MW(MW)) u_min (
    .clk(clk), .rst_n(rst_n), .met_i(metric), .surv_i(surv), .best_o(best)
  );

  always_comb begin
    done_d = fin;
    bits_d = fin ? best : bits_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      bits_q <= '0;
    end else begin
      done_q <= done_d;
      bits_q <= bits_d;
    end
  end

  assign done_o = done_q;
  assign bits_o = bits_q;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_bits_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(bits_o));

endmodule

// File: tb/rex_viterbi_tb.sv
`timescale 1ns/1ps
module rex_viterbi_tb;

  localparam int N    = 8;
  localparam int MWB  = $clog2(2 * N + 1);
  localparam int MAXB = (1 << MWB) - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   sym;
  logic         done_o;
  logic [N-1:0] bits_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rex_viterbi #(.TB_LEN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .sym_i(sym),
    .done_o(done_o), .bits_o(bits_o)
  );

  // ---------------- behavioural reference model ----------------
  int           mm [8];
  logic [N-1:0] ms [8];
  int           mode;      // 0 idle, 1 running, 2 final
  int           taken;
  logic         exp_done;
  logic [N-1:0] exp_bits;

  function automatic int ones2(input logic [1:0] v);
    return int'(v[1]) + int'(v[0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode = 0; taken = 0; exp_done = 1'b0; exp_bits = '0;
      for (int q = 0; q < 8; q++) begin mm[q] = 0; ms[q] = '0; end
    end else begin
      exp_done = 1'b0;
      if (mode == 0) begin
        if (start) begin
          for (int q = 0; q < 8; q++) begin
            mm[q] = (q == 0) ? 0 : MAXB;
            ms[q] = '0;
          end
          mode = 1; taken = 0;
        end
      end else if (mode == 1) begin
        int           nm [8];
        logic [N-1:0] ns [8];
        for (int q = 0; q < 8; q++) begin
          int   inb, a, b, ca, cb, pick;
          logic [2:0] pa, pb;
          inb = q / 4;
          a = (q % 4) * 2; b = a + 1;
          pa = 3'(a); pb = 3'(b);
          ca = mm[a] + ones2({inb[0] ^ pa[2] ^ pa[1] ^ pa[0], inb[0] ^ pa[1] ^ pa[0]} ^ sym);
          cb = mm[b] + ones2({inb[0] ^ pb[2] ^ pb[1] ^ pb[0], inb[0] ^ pb[1] ^ pb[0]} ^ sym);
          pick = (cb < ca) ? b : a;
          nm[q] = (cb < ca) ? cb : ca;
          if (nm[q] > MAXB) nm[q] = MAXB;
          ns[q] = {ms[pick][N-2:0], inb[0]};
        end
        for (int q = 0; q < 8; q++) begin mm[q] = nm[q]; ms[q] = ns[q]; end
        taken++;
        if (taken == N) mode = 2;
      end else begin
        int bi;
        bi = 0;
        for (int q = 1; q < 8; q++) if (mm[q] < mm[bi]) bi = q;
        exp_bits = ms[bi];
        exp_done = 1'b1;
        mode = 0;
      end
    end
  end

  // every-cycle comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (done_o !== exp_done) begin
        fails++;
        $display("FAIL R7 done_o: actual %b expected %b at %0t", done_o, exp_done, $time);
      end
      checks++;
      if (bits_o !== exp_bits) begin
        fails++;
        $display("FAIL R2 R3 R4 R5 R6 bits_o: actual %h expected %h at %0t", bits_o, exp_bits, $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] want);
    checks++;
    if (act !== want) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, want);
    end
  endtask

  // encoder (R1) plus channel errors; first symbol carries bit N-1
  task automatic run_block(input logic [N-1:0] data, input logic [2*N-1:0] err,
                           input bit mid_start, input bit exact,
                           input logic [N-1:0] want, input string tag);
    logic [2:0] st;
    st = 3'b000;
    start = 1'b1;
    for (int k = 0; k < N; k++) begin
      logic ib;
      @(negedge clk);
      ib    = data[N-1-k];
      start = mid_start && (k == 2);
      sym   = {ib ^ st[2] ^ st[1] ^ st[0], ib ^ st[1] ^ st[0]} ^ err[2*k +: 2];
      st    = {ib, st[2:1]};
    end
    @(negedge clk);
    start = mid_start;   // R8: start during the final cycle is also ignored
    sym   = 2'b00;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (done_o !== 1'b1) begin
      fails++;
      $display("FAIL R7 done at cycle N+2: actual %b expected 1", done_o);
    end
    if (exact) check(tag, bits_o, want);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    sym   = 2'b00;
    repeat (n) @(negedge clk);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    sym   = 2'b00;
    repeat (3) @(negedge clk);
    checks++;
    if (done_o !== 1'b0) begin fails++; $display("FAIL R10 done in reset: actual %b expected 0", done_o); end
    check("R10 bits in reset", bits_o, '0);
    rst_n = 1'b1;
    idle(2);

    // R1 R9: error-free blocks decode to the input
    run_block(8'h00, '0, 1'b0, 1'b1, 8'h00, "R1 R9 zeros");
    idle(1);
    run_block(8'hFF, '0, 1'b0, 1'b1, 8'hFF, "R1 R9 ones");
    run_block(8'hA5, '0, 1'b0, 1'b1, 8'hA5, "R7 R9 back-to-back");
    run_block(8'h3C, '0, 1'b0, 1'b1, 8'h3C, "R7 R9 back-to-back 2");
    idle(3);

    // R2 R3: a single error in the first symbol is corrected
    run_block(8'h00, 16'h0001, 1'b0, 1'b1, 8'h00, "R2 R3 first-symbol error");
    idle(1);
    // R6: error in last symbol ties states 0 and 4; state 0 wins
    run_block(8'h00, 16'h4000, 1'b0, 1'b1, 8'h00, "R6 final tie");
    idle(1);
    run_block(8'h00, 16'h8000, 1'b0, 1'b1, 8'h00, "R6 final tie other bit");
    idle(2);

    // R8: starts during a block are ignored
    run_block(8'hB4, '0, 1'b1, 1'b1, 8'hB4, "R8 mid-block start");
    idle(2);

    // R4 R5: random data with and without errors, compared against the model
    for (int t = 0; t < 12; t++) begin
      logic [N-1:0]   d;
      logic [2*N-1:0] e;
      d = N'($urandom);
      e = (t % 3 == 0) ? '0 : (16'h1 << ($urandom % 16)) | (16'h1 << ($urandom % 16));
      run_block(d, e, 1'b0, (t % 3 == 0), d, "R4 R9 random error-free");
      idle(t % 2);
    end
    idle(4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R7 watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule